// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog counter that advances on a low-frequency clock-enable tick inside the system clock domain. Software arms it through a control register that holds an enable bit and a period-select field. That register is protected by a two-step key handshake, so a single stray store cannot switch the watchdog off or change its period. A separate clear register restarts the count on any write. If the count reaches the selected period before software clears it, the block pulses a soft-reset request for one cycle. The next period then starts from zero at once and keeps running while the reset sequencer acts on the pulse.

The block also sits in the path of the sleep-mode request. While the watchdog is enabled, a request for the deepest (static) sleep state is turned into a shutdown request, so the tick source and the counter keep running. A plain write strobe with a one-bit address is the only bus access.

Top module: `kw_wdt`

## Requirements
- R1: After asynchronous reset, `en_o`, `rc_en_o` and `srst_o` are 0 and `psel_o` is 0.
- R2: `rc_en_o`, the enable for the tick clock source, follows the committed enable bit.
- R3: With the watchdog enabled and select value P, the N-th tick after enable or after a clear, where N = 2^(P+1), raises `srst_o` in the cycle that follows that tick. Earlier ticks do not raise it.
- R4: A write to address 0 with key byte `wr_data_i[31:24]` = 0x55, followed by a write to address 0 with key 0xAA and identical bits [23:0], loads enable = bit 0 and select = bits [5:1]. Writes to address 1 between the two steps do not break the sequence.
- R5: A 0xAA write without a preceding 0x55 write is discarded and leaves the control register unchanged. So is a 0xAA write whose bits [23:0] differ from those of the 0x55 write, including the reserved bits [23:6], and so is a 0xAA write that follows a control write with any other key.
- R6: A write of any value to address 1 while enabled restarts the count from zero. This includes a write in the same cycle as the tick that would otherwise expire the count.
- R7: `srst_o` is high for exactly one system clock cycle per expiry.
- R8: After an expiry, the next period begins immediately without any clear, and another pulse follows after N more ticks.
- R9: The counter is held at zero while disabled, so every enable starts a full period.
- R10: `sleep_mode_o` equals `sleep_req_i` (0 run, 1 idle, 2 shutdown, 3 static), except that a static request while enabled becomes shutdown.
- R11: While disabled, `srst_o` stays 0 whatever the tick input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Low-frequency count enable, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 selects control, 1 selects clear |
| wr_data_i | input | 32 | Write data; key in bits [31:24] |
| sleep_req_i | input | 2 | Requested sleep mode |
| en_o | output | 1 | Committed enable bit |
| psel_o | output | 5 | Committed period select |
| rc_en_o | output | 1 | Tick clock source enable |
| srst_o | output | 1 | Soft-reset request pulse |
| sleep_mode_o | output | 2 | Sleep mode passed on after redirection |

## Verification
The hardest situations to reach from the ports are the broken key handshakes and a clear that lands on the very tick that would expire the count. The bench builds each broken handshake on purpose: a commit with no arm, a commit whose select or reserved bits differ, and a foreign-key control write between arm and commit. After each one it reads the control outputs. For the clear race it drives a tick and a clear write in the same cycle once N-1 ticks have passed, then counts a further full period to find where the pulse lands. Every select value from 0 to 4 is swept, with the pulse position checked after each individual tick.

// File: rtl/kw_wdt_pkg.sv
package kw_wdt_pkg;
  typedef enum logic [1:0] {
    SLP_RUN      = 2'd0,
    SLP_IDLE     = 2'd1,
    SLP_SHUTDOWN = 2'd2,
    SLP_STATIC   = 2'd3
  } slp_mode_e;

  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_CLR  = 1'b1
  } wr_addr_e;
endpackage

// File: rtl/kw_wdt_ctrl.sv
module kw_wdt_ctrl
  import kw_wdt_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PSEL_W     = 5,
  parameter int unsigned KEY_W      = 8,
  parameter logic [KEY_W-1:0] KEY_ARM    = 8'h55,
  parameter logic [KEY_W-1:0] KEY_COMMIT = 8'hAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              en_o,
  output logic [PSEL_W-1:0] psel_o
);
  localparam int unsigned PAY_W = DATA_W - KEY_W;
  localparam int unsigned REG_W = PSEL_W + 1;

  logic [KEY_W-1:0] key;
  logic [PAY_W-1:0] pay, held_q;
  logic [REG_W-1:0] ctrl_q;
  logic             armed_q, ctrl_wr;

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign key     = wr_data_i[DATA_W-1 -: KEY_W];
  assign pay     = wr_data_i[PAY_W-1:0];

  // one-bit key state; the whole non-key word is latched for the match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      held_q  <= '0;
      ctrl_q  <= '0;
    end else if (ctrl_wr) begin
      if (key == KEY_ARM) begin
        armed_q <= 1'b1;
        held_q  <= pay;
      end else begin
        armed_q <= 1'b0;
        if (key == KEY_COMMIT && armed_q && pay == held_q) ctrl_q <= pay[REG_W-1:0];
      end
    end
  end

  assign en_o   = ctrl_q[0];
  assign psel_o = ctrl_q[REG_W-1:1];
endmodule

// File: rtl/kw_wdt_counter.sv
module kw_wdt_counter #(
  parameter int unsigned PSEL_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic              tick_i,
  input  logic              clr_i,
  output logic              srst_o
);
  localparam int unsigned CNT_W = (1 << PSEL_W) + 1;

  logic [CNT_W-1:0]  cnt_q, limit;
  logic [PSEL_W:0]   shamt;
  logic              expire, srst_q;

  assign shamt  = {1'b0, psel_i} + (PSEL_W+1)'(1);
  assign limit  = (CNT_W'(1) << shamt) - CNT_W'(1);
  // >= covers a select shrunk below the running count
  assign expire = en_i && tick_i && !clr_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= expire;
      if (!en_i || clr_i)  cnt_q <= '0;
      else if (tick_i)     cnt_q <= expire ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign srst_o = srst_q;
endmodule

// File: rtl/kw_wdt_sleep.sv
module kw_wdt_sleep
  import kw_wdt_pkg::*;
(
  input  logic       en_i,
  input  logic [1:0] req_i,
  output logic [1:0] mode_o
);
  slp_mode_e req, mode;

  always_comb begin
    req  = slp_mode_e'(req_i);
    mode = req;
    if (en_i && req == SLP_STATIC) mode = SLP_SHUTDOWN;
  end

  assign mode_o = mode;
endmodule

// File: rtl/kw_wdt.sv
module kw_wdt
  import kw_wdt_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PSEL_W     = 5,
  parameter int unsigned KEY_W      = 8,
  parameter logic [KEY_W-1:0] KEY_ARM    = 8'h55,
  parameter logic [KEY_W-1:0] KEY_COMMIT = 8'hAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        sleep_req_i,
  output logic              en_o,
  output logic [PSEL_W-1:0] psel_o,
  output logic              rc_en_o,
  output logic              srst_o,
  output logic [1:0]        sleep_mode_o
);
  logic              en;
  logic [PSEL_W-1:0] psel;
  logic              clr_wr;

  assign clr_wr = wr_en_i && (wr_addr_i == ADDR_CLR);

  kw_wdt_ctrl #(
    .DATA_W(DATA_W), .PSEL_W(PSEL_W), .KEY_W(KEY_W),
    .KEY_ARM(KEY_ARM), .KEY_COMMIT(KEY_COMMIT)
  ) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_o(en), .psel_o(psel)
  );

  kw_wdt_counter #(.PSEL_W(PSEL_W)) u_cnt (
    .clk_i, .rst_ni, .en_i(en), .psel_i(psel), .tick_i,
    .clr_i(clr_wr), .srst_o
  );

  kw_wdt_sleep u_slp (.en_i(en), .req_i(sleep_req_i), .mode_o(sleep_mode_o));

  assign en_o    = en;
  assign psel_o  = psel;
  assign rc_en_o = en;
endmodule

// File: rtl/kw_wdt_chk.sv
module kw_wdt_chk #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PSEL_W     = 5,
  parameter int unsigned KEY_W      = 8,
  parameter logic [KEY_W-1:0] KEY_ARM    = 8'h55,
  parameter logic [KEY_W-1:0] KEY_COMMIT = 8'hAA
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [1:0]        sleep_req_i,
  input logic              en_o,
  input logic [PSEL_W-1:0] psel_o,
  input logic              srst_o,
  input logic [1:0]        sleep_mode_o
);
  p_srst_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> !srst_o);

  p_ctrl_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && !wr_addr_i && wr_data_i[DATA_W-1 -: KEY_W] == KEY_COMMIT)
    |=> $stable({en_o, psel_o}));

  p_clear_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i) |=> !srst_o);

  p_no_srst_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_o) |-> !srst_o);

  p_static_redirect_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && sleep_req_i == 2'd3) |-> sleep_mode_o == 2'd2);

  p_sleep_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_req_i != 2'd3) |-> sleep_mode_o == sleep_req_i);
endmodule

bind kw_wdt kw_wdt_chk #(
  .DATA_W(DATA_W), .PSEL_W(PSEL_W), .KEY_W(KEY_W),
  .KEY_ARM(KEY_ARM), .KEY_COMMIT(KEY_COMMIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .sleep_req_i(sleep_req_i), .en_o(en_o),
  .psel_o(psel_o), .srst_o(srst_o), .sleep_mode_o(sleep_mode_o)
);

// File: tb/kw_wdt_test.sv
module kw_wdt_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_addr_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  sleep_req_i = '0;
  logic        en_o, rc_en_o, srst_o;
  logic [4:0]  psel_o;
  logic [1:0]  sleep_mode_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  kw_wdt uut (
    .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .sleep_req_i, .en_o, .psel_o, .rc_en_o, .srst_o, .sleep_mode_o
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] key, input logic en,
                                     input logic [4:0] ps, input logic [17:0] resv);
    return {key, resv, ps, en};
  endfunction

  task automatic bus_wr(input logic addr, input logic [31:0] data, input logic tk);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = addr; wr_data_i = data; tick_i = tk;
    @(negedge clk_i);
    wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic ctrl_set(input logic en, input logic [4:0] ps);
    bus_wr(1'b0, mk(8'h55, en, ps, '0), 1'b0);
    bus_wr(1'b0, mk(8'hAA, en, ps, '0), 1'b0);
  endtask

  task automatic tick1();
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  // n ticks; srst checked after every tick, expected only after the last when pulse_last
  task automatic run_ticks(input int n, input logic pulse_last, input string req);
    for (int i = 1; i <= n; i++) begin
      tick1();
      check(req, srst_o, (i == n) && pulse_last);
    end
  endtask

  task automatic ctrl_expect(input logic en, input logic [4:0] ps, input string req);
    check(req, en_o, en);
    check(req, psel_o, ps);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", {en_o, rc_en_o, srst_o}, 3'b000);
    check("R1", psel_o, 5'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", {en_o, rc_en_o, srst_o}, 3'b000);

    // R3/R7/R8/R6/R2 sweep over select values
    for (int p = 0; p <= 4; p++) begin
      int n;
      n = 1 << (p + 1);
      ctrl_set(1'b1, 5'(p));
      ctrl_expect(1'b1, 5'(p), "R4");
      check("R2", rc_en_o, 1'b1);
      run_ticks(n, 1'b1, "R3");
      @(negedge clk_i);
      check("R7", srst_o, 1'b0);
      run_ticks(n, 1'b1, "R8");
      // clear mid-period
      run_ticks(n - 1, 1'b0, "R6");
      bus_wr(1'b1, 32'hDEAD_BEEF, 1'b0);
      run_ticks(n, 1'b1, "R6");
      // clear on the expiring tick
      run_ticks(n - 1, 1'b0, "R6");
      bus_wr(1'b1, 32'h0, 1'b1);
      check("R6", srst_o, 1'b0);
      run_ticks(n, 1'b1, "R6");
      ctrl_set(1'b0, 5'(p));
      ctrl_expect(1'b0, 5'(p), "R4");
      check("R2", rc_en_o, 1'b0);
    end

    // R5 broken sequences; base state disabled, select 2
    ctrl_set(1'b0, 5'd2);
    bus_wr(1'b0, mk(8'hAA, 1'b1, 5'd7, '0), 1'b0);
    ctrl_expect(1'b0, 5'd2, "R5 commit without arm");
    bus_wr(1'b0, mk(8'h55, 1'b1, 5'd3, '0), 1'b0);
    bus_wr(1'b0, mk(8'hAA, 1'b1, 5'd4, '0), 1'b0);
    ctrl_expect(1'b0, 5'd2, "R5 select mismatch");
    bus_wr(1'b0, mk(8'h55, 1'b1, 5'd3, 18'h00010), 1'b0);
    bus_wr(1'b0, mk(8'hAA, 1'b1, 5'd3, 18'h00000), 1'b0);
    ctrl_expect(1'b0, 5'd2, "R5 reserved mismatch");
    bus_wr(1'b0, mk(8'h55, 1'b1, 5'd3, '0), 1'b0);
    bus_wr(1'b0, mk(8'h12, 1'b1, 5'd3, '0), 1'b0);
    bus_wr(1'b0, mk(8'hAA, 1'b1, 5'd3, '0), 1'b0);
    ctrl_expect(1'b0, 5'd2, "R5 foreign key between");
    bus_wr(1'b0, mk(8'hAA, 1'b1, 5'd3, '0), 1'b0);
    bus_wr(1'b0, mk(8'h55, 1'b1, 5'd3, '0), 1'b0);
    ctrl_expect(1'b0, 5'd2, "R5 wrong order");
    // R4: clear write between arm and commit keeps the sequence
    bus_wr(1'b0, mk(8'h55, 1'b1, 5'd1, '0), 1'b0);
    bus_wr(1'b1, 32'h1234_5678, 1'b0);
    bus_wr(1'b0, mk(8'hAA, 1'b1, 5'd1, '0), 1'b0);
    ctrl_expect(1'b1, 5'd1, "R4 clear between");
    // R4: matching non-zero reserved bits commit
    bus_wr(1'b0, mk(8'h55, 1'b1, 5'd2, 18'h2A5A5), 1'b0);
    bus_wr(1'b0, mk(8'hAA, 1'b1, 5'd2, 18'h2A5A5), 1'b0);
    ctrl_expect(1'b1, 5'd2, "R4 reserved match");

    // R9: partial count discarded by disable/enable
    run_ticks(5, 1'b0, "R9");
    ctrl_set(1'b0, 5'd2);
    ctrl_set(1'b1, 5'd2);
    run_ticks(8, 1'b1, "R9");
    ctrl_set(1'b0, 5'd2);

    // R11: disabled, many ticks, including back-to-back
    begin
      int seen;
      seen = 0;
      @(negedge clk_i); tick_i = 1'b1;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk_i);
        if (srst_o) seen++;
      end
      tick_i = 1'b0;
      check("R11", seen, 0);
    end

    // R10: sleep mapping, both enable states
    for (int e = 0; e < 2; e++) begin
      ctrl_set(e[0], 5'd4);
      for (int r = 0; r < 4; r++) begin
        @(negedge clk_i); sleep_req_i = 2'(r);
        #1;
        check("R10", sleep_mode_o, (e == 1 && r == 3) ? 2'd2 : 2'(r));
      end
    end
    sleep_req_i = '0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule